// File: doc/BRIEF.md
# Gated Reference Clock Divider

This block produces an auxiliary clock output from a reference clock. Four power-of-two division ratios are available. The output is switched off whenever the applied operating mode is Sleep, or when the software clock-enable bit is cleared. Rate and gating changes take effect only at phase boundaries of the divided clock, so the output never carries a shortened pulse.

The block also handles the power-up period. After reset it reports Standby and drives the slowest rate (reference divided by 32), even though the configuration inputs all read zero. The first rising edge of the active-low bus enable strobe ends this period. That edge is synchronised into the reference domain, and from then on the configuration inputs are obeyed. Every rising edge of the strobe, including the first, captures the mode pins as the applied operating mode.

There is no data stream here, so there is no valid/ready interface. All pins are plain control and status signals.

Top module: `clk_out_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until the first strobe edge, `op_mode` reads 3'b001 (Standby) and `clk_out` starts low.
- R2: Before the first synchronised rising edge of `bus_en_n`, `clk_out` toggles at reference/32 (16 cycles high, 16 low), whatever the values of `cfg_clk_en` and `cfg_rate`.
- R3: A rising edge of `bus_en_n` passes through a two-stage synchroniser and copies `mode_pins` into `op_mode`. The new value is visible within 4 reference cycles. At any other time `op_mode` ignores `mode_pins`.
- R4: After the first strobe edge, `cfg_rate` selects the division ratio: 2'b00 gives /32, 2'b01 gives /16, 2'b10 gives /8 and 2'b11 gives /4. The output has 50% duty, so it stays high for 16, 8, 4 or 2 reference cycles.
- R5: After the first strobe edge, `cfg_clk_en` low holds `clk_out` low within 64 reference cycles.
- R6: When `op_mode` is 3'b000 (Sleep), `clk_out` is held low within 64 reference cycles.
- R7: New rate and gating settings are loaded only at the end of a high phase or at the end of a low phase. Each high phase therefore lasts the full half-period of the rate in force when it began, and each low phase lasts at least 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pins | input | 3 | Requested operating mode, captured on strobe edges |
| bus_en_n | input | 1 | Active-low bus enable strobe, asynchronous |
| cfg_clk_en | input | 1 | Configuration bit that enables the output clock |
| cfg_rate | input | 2 | Configuration rate select |
| clk_out | output | 1 | Divided and gated output clock |
| op_mode | output | 3 | Applied operating mode |

## Verification
Two events can land in the same reference cycle: a change of rate select and a high phase of the output that is already running. The bench provokes this by waiting for a pulse at /32 to begin and then switching `cfg_rate` to /4 while that pulse is still high. The scoreboard expects one 16-cycle pulse followed by 2-cycle pulses. The checker also requires every high phase to have a power-of-two length and every low phase to last at least two cycles.

// File: rtl/clk_out_pkg.sv
package clk_out_pkg;
  localparam int MODE_W  = 3;
  localparam int RATE_W  = 2;
  localparam logic [MODE_W-1:0] MODE_SLEEP   = 3'b000;
  localparam logic [MODE_W-1:0] MODE_STANDBY = 3'b001;
  localparam logic [RATE_W-1:0] RATE_SLOWEST = '0;

  typedef struct packed {
    logic              gate;
    logic [RATE_W-1:0] rate;
  } clk_setting_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic strobe_n,
  output logic rise,
  output logic first_seen
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Idle level of the strobe is high, so all stages reset high.
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_n};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)    first_seen <= 1'b0;
    else if (rise) first_seen <= 1'b1;
  end
endmodule

// File: rtl/mode_latch.sv
module mode_latch
  import clk_out_pkg::*;
(
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              rise,
  input  logic [MODE_W-1:0] mode_pins,
  output logic [MODE_W-1:0] op_mode
);
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)    op_mode <= MODE_STANDBY;
    else if (rise) op_mode <= mode_pins;
  end
endmodule

// File: rtl/setting_select.sv
module setting_select
  import clk_out_pkg::*;
(
  input  logic              first_seen,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              cfg_clk_en,
  input  logic [RATE_W-1:0] cfg_rate,
  output clk_setting_t      req
);
  logic awake;
  logic allowed;

  always_comb begin
    awake    = (op_mode != MODE_SLEEP);
    // Before the first strobe the power-up override forces the clock on.
    allowed  = first_seen ? cfg_clk_en : 1'b1;
    req.gate = awake & allowed;
    req.rate = first_seen ? cfg_rate : RATE_SLOWEST;
  end
endmodule

// File: rtl/rate_divider.sv
module rate_divider
  import clk_out_pkg::*;
#(
  parameter int MIN_SHIFT = 1
) (
  input  logic         clk_ref,
  input  logic         rst_n,
  input  clk_setting_t req,
  output logic         clk_out
);
  localparam int NRATES  = 1 << RATE_W;
  localparam int MAX_IDX = NRATES - 1;
  localparam int CNT_W   = MIN_SHIFT + MAX_IDX;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  half_m1;
  logic              wrap;
  logic              out_q;
  clk_setting_t      applied_q;
  int unsigned       shift;

  always_comb begin
    shift   = MIN_SHIFT + MAX_IDX - 32'(applied_q.rate);
    half_m1 = CNT_W'((32'd1 << shift) - 32'd1);
    wrap    = (cnt_q == half_m1);
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q          <= '0;
      out_q          <= 1'b0;
      applied_q.gate <= 1'b1;
      applied_q.rate <= RATE_SLOWEST;
    end else if (wrap) begin
      cnt_q <= '0;
      if (out_q) begin
        out_q     <= 1'b0;
        applied_q <= req;
      end else if (applied_q.gate) begin
        out_q <= 1'b1;
      end else begin
        applied_q <= req;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_out = out_q;
endmodule

// File: rtl/clk_out_ctrl.sv
module clk_out_ctrl
  import clk_out_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_SHIFT   = 1
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              bus_en_n,
  input  logic              cfg_clk_en,
  input  logic [RATE_W-1:0] cfg_rate,
  output logic              clk_out,
  output logic [MODE_W-1:0] op_mode
);
  logic         strobe_rise;
  logic         first_seen;
  clk_setting_t req;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .strobe_n   (bus_en_n),
    .rise       (strobe_rise),
    .first_seen (first_seen)
  );

  mode_latch u_mode (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .rise      (strobe_rise),
    .mode_pins (mode_pins),
    .op_mode   (op_mode)
  );

  setting_select u_sel (
    .first_seen (first_seen),
    .op_mode    (op_mode),
    .cfg_clk_en (cfg_clk_en),
    .cfg_rate   (cfg_rate),
    .req        (req)
  );

  rate_divider #(.MIN_SHIFT(MIN_SHIFT)) u_div (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .req     (req),
    .clk_out (clk_out)
  );
endmodule

// File: rtl/clk_out_checker.sv
module clk_out_checker
  import clk_out_pkg::*;
(
  input logic              clk_ref,
  input logic              rst_n,
  input logic              clk_out,
  input logic [MODE_W-1:0] op_mode,
  input logic              cfg_clk_en,
  input logic              rise,
  input logic              first_seen
);
  localparam int SETTLE = 64;

  logic [7:0] hi_run, lo_run, sleep_run, off_run;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0; lo_run <= '0; sleep_run <= '0; off_run <= '0;
    end else begin
      hi_run    <= clk_out ? ((hi_run == 8'hff) ? hi_run : hi_run + 1'b1) : 8'd0;
      lo_run    <= !clk_out ? ((lo_run == 8'hff) ? lo_run : lo_run + 1'b1) : 8'd0;
      sleep_run <= (op_mode == MODE_SLEEP)
                   ? ((sleep_run == 8'hff) ? sleep_run : sleep_run + 1'b1) : 8'd0;
      off_run   <= (first_seen && !cfg_clk_en)
                   ? ((off_run == 8'hff) ? off_run : off_run + 1'b1) : 8'd0;
    end
  end

  assert_standby_before_strobe_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !first_seen |-> op_mode == MODE_STANDBY);

  assert_mode_only_on_edge_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(op_mode) |-> $past(rise));

  assert_disabled_quiet_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (off_run >= 8'(SETTLE)) |-> !clk_out);

  assert_sleep_quiet_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (sleep_run >= 8'(SETTLE)) |-> !clk_out);

  assert_high_width_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(clk_out) |-> ($countones(hi_run) == 1 && hi_run >= 8'd2));

  assert_low_width_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(clk_out) |-> lo_run >= 8'd2);
endmodule

bind clk_out_ctrl clk_out_checker i_chk (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .clk_out    (clk_out),
  .op_mode    (op_mode),
  .cfg_clk_en (cfg_clk_en),
  .rise       (strobe_rise),
  .first_seen (first_seen)
);

// File: tb/test_clk_out_ctrl.sv
module test_clk_out_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk_ref = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_pins = 3'b000;
  logic       bus_en_n = 1'b1;
  logic       cfg_clk_en = 1'b0;
  logic [1:0] cfg_rate = 2'b00;
  logic       clk_out;
  logic [2:0] op_mode;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  int exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  clk_out_ctrl i_clk_out_ctrl (
    .clk_ref(clk_ref), .rst_n(rst_n), .mode_pins(mode_pins), .bus_en_n(bus_en_n),
    .cfg_clk_en(cfg_clk_en), .cfg_rate(cfg_rate), .clk_out(clk_out), .op_mode(op_mode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures each high phase, pops an expected width if tracked.
  bit prev_out = 0;
  bit tracked = 0;
  int run = 0;
  always @(negedge clk_ref) begin
    cycles++;
    if (rst_n) begin
      if (clk_out && !prev_out) begin
        run = 1;
        tracked = (exp_q.size() > 0);
      end else if (clk_out) begin
        run++;
      end else if (prev_out && tracked) begin
        check(run == exp_q[0], tag_q[0], run, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
        tracked = 0;
      end
      prev_out = clk_out;
    end
  end

  task automatic push(input int width, input string req);
    exp_q.push_back(width);
    tag_q.push_back(req);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && exp_q.size() > 0; i++) @(negedge clk_ref);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_ref);
      if (clk_out) highs++;
    end
  endtask

  task automatic strobe(input logic [2:0] m);
    mode_pins = m;
    bus_en_n = 1'b0;
    idle(4);
    bus_en_n = 1'b1;
    idle(6);
  endtask

  task automatic expect_rate(input logic [1:0] r, input int width, input string req);
    cfg_rate = r;
    idle(80);
    for (int k = 0; k < 3; k++) push(width, req);
    drain();
  endtask

  initial begin
    while (!done) begin
      @(negedge clk_ref);
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int highs;
    idle(3);
    // R1: reset state
    check(op_mode == 3'b001, "R1 op_mode in reset", op_mode, 1);
    check(clk_out == 1'b0, "R1 clk_out low in reset", clk_out, 0);
    rst_n = 1'b1;
    idle(2);
    check(op_mode == 3'b001, "R1 op_mode after reset", op_mode, 1);

    // R2: power-up override, rate and enable inputs ignored
    cfg_clk_en = 1'b0;
    cfg_rate = 2'b11;
    mode_pins = 3'b000;
    for (int k = 0; k < 3; k++) push(16, "R2 powerup /32 high width");
    drain();
    check(op_mode == 3'b001, "R3 mode pins ignored without strobe", op_mode, 1);

    // R3 and R5: first edge latches mode, enable bit low stops clock
    strobe(3'b001);
    check(op_mode == 3'b001, "R3 first strobe latches 001", op_mode, 1);
    idle(80);
    count_high(100, highs);
    check(highs == 0, "R5 enable low holds clk_out low", highs, 0);

    // R4: every rate
    cfg_clk_en = 1'b1;
    expect_rate(2'b11, 2, "R4 rate 11 /4");
    expect_rate(2'b10, 4, "R4 rate 10 /8");
    expect_rate(2'b01, 8, "R4 rate 01 /16");
    expect_rate(2'b00, 16, "R4 rate 00 /32");

    // R7: rate change during a running high phase
    while (clk_out) @(negedge clk_ref);
    push(16, "R7 running pulse keeps width");
    push(2, "R7 new rate after fall");
    push(2, "R7 new rate steady");
    while (!clk_out) @(negedge clk_ref);
    idle(3);
    cfg_rate = 2'b11;
    drain();

    // R6: Sleep via strobe
    strobe(3'b000);
    check(op_mode == 3'b000, "R3 strobe latches 000", op_mode, 0);
    idle(80);
    count_high(100, highs);
    check(highs == 0, "R6 sleep holds clk_out low", highs, 0);

    // R3: pins change without strobe
    mode_pins = 3'b101;
    idle(20);
    check(op_mode == 3'b000, "R3 pins ignored between strobes", op_mode, 0);

    // Wake again
    strobe(3'b101);
    check(op_mode == 3'b101, "R3 strobe latches 101", op_mode, 5);
    expect_rate(2'b10, 4, "R4 rate 10 after wake");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule